// File: doc/BRIEF.md
# Snapshot Sample-Hold Readout Sequencer

This block produces the digital timing for a multi-channel recording front end that freezes every channel at one instant and then drains the held values, one channel at a time, through a single shared charge amplifier into one converter. A programmable frame timer counts system clocks. On each frame tick the sequencer fires one global hold strobe, so all 64 sample capacitors capture together with no skew between them. It then walks the channels in ascending order. For each channel it clears the output amplifier's feedback capacitor, leaves a one-clock dead gap, closes that channel's transfer switch so its charge moves onto the amplifier, strobes the converter once the output has settled, and leaves a second dead gap before the next channel.

The sample capacitors, the amplifier and the converter are outside the block. They appear here only as control outputs. All pins are plain control or status lines, because no data word passes through this logic. If a tick arrives while a frame is still being read out, the next hold is deferred until the readout ends, and a sticky overrun flag records the event. Dropping the enable returns everything to idle on the next clock.

Top module: `snap_readout_seq`

## Requirements
- R1: `sample_hold` is a one-clock pulse. After `enable` rises with period P ≥ 1, the first pulse appears after the P-th enabled clock edge. Frame ticks then recur every P enabled clocks, and a tick that finds the sequencer idle starts a frame on the next edge.
- R2: Channels are read in ascending order 0..63. While channel k is being transferred, only bit k of `xfer_sel` is set, and `ch_idx` equals k throughout channel k's slot.
- R3: At most one bit of `xfer_sel` is ever set.
- R4: Each channel slot lasts 8 clocks and runs in this order: `amp_reset` for 2 clocks, 1 clock with both low, `xfer_sel` for 4 clocks, then 1 clock with both low. The first slot begins on the clock right after `sample_hold`. Reset and transfer never overlap.
- R5: `adc_convert` pulses exactly once per channel, 2 clocks after that channel's `xfer_sel` bit rises, while the bit is still high.
- R6: `frame_start` pulses on the first transfer clock of channel 0. `frame_done` pulses on the clock after channel 63's trailing gap, which is 513 clocks after `sample_hold`.
- R7: A tick that arrives between `sample_hold` and `frame_done` (inclusive) does not start a frame. Instead, the next `sample_hold` comes on the clock right after `frame_done`. Any number of such ticks during one frame yield one deferred frame.
- R8: `overrun` goes high on the clock edge of any tick that arrives between `sample_hold` and `frame_done`. It stays high while `enable` stays high.
- R9: A clock edge with `enable` low leaves every strobe, select and flag low, `ch_idx` at 0, `overrun` cleared and the frame timer restarted.
- R10: While `rst_n` is low, all outputs are low and `ch_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous run enable; low forces idle |
| frame_period | input | 16 | Frame length in system clocks (change only while disabled) |
| sample_hold | output | 1 | Global hold strobe for all channels |
| xfer_sel | output | 64 | One-hot transfer switch select |
| amp_reset | output | 1 | Output-amplifier feedback capacitor reset |
| adc_convert | output | 1 | Converter start strobe |
| ch_idx | output | 6 | Channel currently in its readout slot |
| frame_start | output | 1 | Marks the first transfer clock of channel 0 |
| frame_done | output | 1 | One-clock pulse after the last channel |
| overrun | output | 1 | Sticky flag: frame tick arrived during readout |

## Verification
The bench targets three boundaries. The first is the period boundary at 514 versus 515 clocks: a design that tested busy one cycle too early or too late would miss the overrun flag there, or raise it falsely. The second is the deferred frame. A design that dropped the pending tick would leave a gap of a whole period. A design that queued every tick would chain extra frames, and in both cases the observed hold timing would drift from the model. The third is a disable that lands mid-frame. A sequencer that kept a transfer switch closed, or kept its channel count or timer phase, would show a select bit or a shifted first strobe after re-enable. Reset-to-transfer gaps and the converter offset are checked on every clock, so an off-by-one in any phase counter shows up on the first channel.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_RST,
    ST_GAP_A,
    ST_XFER,
    ST_GAP_B,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/snap_frame_timer.sv
module snap_frame_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  localparam logic [PERIOD_W:0] ONE = 1;

  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W:0]   cnt_next_ext;

  // Tick on the last clock of each period; a period of 0 behaves as 1.
  always_comb begin
    cnt_next_ext = {1'b0, cnt_q} + ONE;
    tick_o       = en_i && (cnt_next_ext >= {1'b0, period_i});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_timer_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/snap_onehot_dec.sv
module snap_onehot_dec #(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic [W-1:0] idx_i,
  input  logic         act_i,
  output logic [N-1:0] sel_o
);
  for (genvar g = 0; g < N; g++) begin : g_sel
    assign sel_o[g] = act_i && (idx_i == W'(g));
  end
endmodule

// File: rtl/snap_seq_core.sv
module snap_seq_core
  import snap_pkg::*;
#(
  parameter int NUM_CH   = 64,
  parameter int CH_W     = 6,
  parameter int RST_CYC  = 2,
  parameter int XFER_CYC = 4,
  parameter int SETTLE   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            tick_i,
  output logic            sample_o,
  output logic            amp_rst_o,
  output logic            xfer_act_o,
  output logic            adc_conv_o,
  output logic [CH_W-1:0] ch_o,
  output logic            frame_start_o,
  output logic            frame_done_o,
  output logic            overrun_o
);
  localparam int MAXPH = (RST_CYC > XFER_CYC) ? RST_CYC : XFER_CYC;
  localparam int PH_W  = $clog2(MAXPH + 1);
  localparam logic [CH_W-1:0] LAST_CH  = CH_W'(NUM_CH - 1);
  localparam logic [PH_W-1:0] RST_END  = PH_W'(RST_CYC - 1);
  localparam logic [PH_W-1:0] XFER_END = PH_W'(XFER_CYC - 1);
  localparam logic [PH_W-1:0] CONV_PH  = PH_W'(SETTLE);

  seq_state_t      state_q, state_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            pend_q, pend_d;
  logic            ov_q, ov_d;
  logic            busy;

  always_comb begin
    busy    = (state_q != ST_IDLE);
    state_d = state_q;
    ph_d    = ph_q;
    ch_d    = ch_q;
    pend_d  = pend_q;
    ov_d    = ov_q;
    if (tick_i && busy) ov_d = 1'b1;
    if (tick_i && busy && (state_q != ST_DONE)) pend_d = 1'b1;
    case (state_q)
      ST_IDLE:   if (tick_i) state_d = ST_SAMPLE;
      ST_SAMPLE: begin
        state_d = ST_RST;
        ph_d    = '0;
        ch_d    = '0;
      end
      ST_RST: begin
        if (ph_q == RST_END) begin
          state_d = ST_GAP_A;
          ph_d    = '0;
        end else ph_d = ph_q + PH_W'(1);
      end
      ST_GAP_A:  state_d = ST_XFER;
      ST_XFER: begin
        if (ph_q == XFER_END) state_d = ST_GAP_B;
        else                  ph_d = ph_q + PH_W'(1);
      end
      ST_GAP_B: begin
        ph_d = '0;
        if (ch_q == LAST_CH) state_d = ST_DONE;
        else begin
          ch_d    = ch_q + CH_W'(1);
          state_d = ST_RST;
        end
      end
      ST_DONE: begin
        if (pend_q || tick_i) begin
          state_d = ST_SAMPLE;
          pend_d  = 1'b0;
        end else state_d = ST_IDLE;
      end
      default:   state_d = ST_IDLE;
    endcase
    if (!en_i) begin
      state_d = ST_IDLE;
      ph_d    = '0;
      ch_d    = '0;
      pend_d  = 1'b0;
      ov_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      ch_q    <= '0;
      pend_q  <= 1'b0;
      ov_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      ch_q    <= ch_d;
      pend_q  <= pend_d;
      ov_q    <= ov_d;
    end
  end

  always_comb begin
    sample_o      = (state_q == ST_SAMPLE);
    amp_rst_o     = (state_q == ST_RST);
    xfer_act_o    = (state_q == ST_XFER);
    adc_conv_o    = xfer_act_o && (ph_q == CONV_PH);
    frame_start_o = xfer_act_o && (ch_q == '0) && (ph_q == '0);
    frame_done_o  = (state_q == ST_DONE);
    ch_o          = ch_q;
    overrun_o     = ov_q;
  end

  assert_gap_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(amp_rst_o) |-> !xfer_act_o);
  assert_gap_after_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_act_o) |-> !amp_rst_o);
  assert_reset_follows_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && en_i) |=> amp_rst_o);
  assert_convert_inside_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv_o |-> xfer_act_o);
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && en_i) |=> overrun_o);
  assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!sample_o && !amp_rst_o && !xfer_act_o && !overrun_o && ch_o == '0));
endmodule

// File: rtl/snap_readout_seq.sv
module snap_readout_seq #(
  parameter int NUM_CH   = 64,
  parameter int PERIOD_W = 16,
  parameter int RST_CYC  = 2,
  parameter int XFER_CYC = 4,
  parameter int SETTLE   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic [PERIOD_W-1:0]       frame_period,
  output logic                      sample_hold,
  output logic [NUM_CH-1:0]         xfer_sel,
  output logic                      amp_reset,
  output logic                      adc_convert,
  output logic [$clog2(NUM_CH)-1:0] ch_idx,
  output logic                      frame_start,
  output logic                      frame_done,
  output logic                      overrun
);
  localparam int CH_W = $clog2(NUM_CH);

  logic tick;
  logic xfer_act;

  snap_frame_timer #(.PERIOD_W(PERIOD_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (enable),
    .period_i (frame_period),
    .tick_o   (tick)
  );

  snap_seq_core #(
    .NUM_CH   (NUM_CH),
    .CH_W     (CH_W),
    .RST_CYC  (RST_CYC),
    .XFER_CYC (XFER_CYC),
    .SETTLE   (SETTLE)
  ) core_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (enable),
    .tick_i        (tick),
    .sample_o      (sample_hold),
    .amp_rst_o     (amp_reset),
    .xfer_act_o    (xfer_act),
    .adc_conv_o    (adc_convert),
    .ch_o          (ch_idx),
    .frame_start_o (frame_start),
    .frame_done_o  (frame_done),
    .overrun_o     (overrun)
  );

  snap_onehot_dec #(.N(NUM_CH), .W(CH_W)) dec_i (
    .idx_i (ch_idx),
    .act_i (xfer_act),
    .sel_o (xfer_sel)
  );

  assert_single_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_sel));
  assert_no_switch_on_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    amp_reset |-> (xfer_sel == '0));
endmodule

// File: tb/snap_readout_seq_tb_top.sv
module snap_readout_seq_tb_top;
  localparam int NCH        = 64;
  localparam int RSTC       = 2;
  localparam int XC         = 4;
  localparam int STL        = 2;
  localparam int SLOT       = RSTC + 1 + XC + 1;
  localparam int FRAME_LAST = 1 + NCH * SLOT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] frame_period = 16'd515;
  logic        sample_hold, amp_reset, adc_convert, frame_start, frame_done, overrun;
  logic [63:0] xfer_sel;
  logic [5:0]  ch_idx;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  bit  en_q = 0;
  int  en_cnt = 0;
  int  d = 0;
  bit  in_frame = 0;
  bit  pend = 0;
  bit  exp_ov = 0;

  always #5 clk = ~clk;

  snap_readout_seq dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_period(frame_period),
    .sample_hold(sample_hold), .xfer_sel(xfer_sel), .amp_reset(amp_reset),
    .adc_convert(adc_convert), .ch_idx(ch_idx), .frame_start(frame_start),
    .frame_done(frame_done), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at t=%0t actual=%h expected=%h", req, $time, act, expv);
    end
  endtask

  // Expected {sample, reset, convert, start, done} for frame offset dd.
  function automatic logic [4:0] exp_ctrl(input int dd);
    int k, p;
    logic [4:0] v;
    v = '0;
    if (dd == 0) v[4] = 1'b1;
    else if (dd == FRAME_LAST) v[0] = 1'b1;
    else begin
      k = (dd - 1) / SLOT;
      p = (dd - 1) % SLOT;
      v[3] = (p < RSTC);
      v[2] = (p == RSTC + 1 + STL);
      v[1] = (k == 0) && (p == RSTC + 1);
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_sel(input int dd);
    int k, p;
    if (dd < 1 || dd >= FRAME_LAST) return '0;
    k = (dd - 1) / SLOT;
    p = (dd - 1) % SLOT;
    if (p >= RSTC + 1 && p <= RSTC + XC) return 64'd1 << k;
    return '0;
  endfunction

  always @(posedge clk) en_q <= enable;

  always @(negedge clk) begin
    logic [4:0] ectl, actl;
    logic [63:0] esel;
    bit tick, busy, start;
    int pp;
    actl = {sample_hold, amp_reset, adc_convert, frame_start, frame_done};
    if (!rst_n || !en_q) begin
      en_cnt = 0; in_frame = 0; pend = 0; exp_ov = 0;
      chk(actl == 5'd0 && xfer_sel == '0, rst_n ? "R9 outputs" : "R10 outputs",
          {actl, xfer_sel[58:0]}, 64'd0);
      chk(ch_idx == 6'd0 && overrun == 1'b0, rst_n ? "R9 ch_idx/overrun" : "R10 ch_idx/overrun",
          {ch_idx, overrun}, 64'd0);
    end else begin
      en_cnt++;
      pp = int'(frame_period);
      tick = (pp == 0) || (en_cnt % pp == 0);
      busy = in_frame;
      start = (tick && !busy) || (busy && d == FRAME_LAST && (pend || tick));
      if (tick && busy) exp_ov = 1;
      if (tick && busy && d != FRAME_LAST) pend = 1;
      if (start) begin d = 0; in_frame = 1; pend = 0; end
      else if (in_frame) begin d++; if (d > FRAME_LAST) in_frame = 0; end
      ectl = in_frame ? exp_ctrl(d) : 5'd0;
      esel = in_frame ? exp_sel(d) : 64'd0;
      chk(actl[4] == ectl[4], "R1 R7 sample_hold", actl[4], ectl[4]);
      chk(actl[3] == ectl[3], "R4 amp_reset", actl[3], ectl[3]);
      chk(actl[2] == ectl[2], "R5 adc_convert", actl[2], ectl[2]);
      chk(actl[1:0] == ectl[1:0], "R6 frame_start/frame_done", actl[1:0], ectl[1:0]);
      chk(xfer_sel == esel, "R2 R3 xfer_sel", xfer_sel, esel);
      chk(overrun == exp_ov, "R8 overrun", overrun, exp_ov);
      if (in_frame && d >= 1 && d < FRAME_LAST)
        chk(ch_idx == 6'((d - 1) / SLOT), "R2 ch_idx", ch_idx, (d - 1) / SLOT);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run(input int p, input int len);
    frame_period = 16'(p);
    enable = 1'b1;
    step(len);
    enable = 1'b0;
    step(4);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    step(3);          // R10 reset state observed by the monitor
    rst_n = 1'b1;
    step(2);
    run(515, 3 * 515 + 20);  // R1 boundary: no overrun
    run(514, 2000);          // R7 R8 boundary: overrun, back-to-back frames
    run(600, 1500);
    run(1, 1200);            // R7 ticks every clock
    run(520, 700);           // R9 disable mid-frame
    run(3, 40);              // R9 disable during first channel
    for (int i = 0; i < 8; i++) begin
      int p, len;
      p   = ($urandom % 3 == 0) ? 100 + int'($urandom % 414) : 515 + int'($urandom % 800);
      len = 200 + int'($urandom % 2500);
      run(p, len);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule